// File: doc/BRIEF.md
# Pedestal-Window ADC Sample Compressor

This block takes one beam crossing's worth of ADC readings (eight 12-bit samples, one crossing every 25 ns) and splits them into two classes. A sample sitting in a narrow band just above the pedestal becomes a short code: its distance from the bottom of the band. Any other sample is flagged as long and keeps its full 12-bit value. For every crossing the block produces four things:

- a packed vector of short codes;
- a per-channel map that marks the long samples;
- the long values, each in its channel's slot;
- the number of long channels, which downstream packing logic uses to account for overflow.

The short-code width is a parameter, 4 or 5 bits. The band grows with it to 16 or 32 codes.

A small two-state controller sits behind the output register. In state ST_IDLE no result is being presented. In state ST_LOAD the registered result of the previous cycle is valid. Two transitions lead into ST_LOAD: T_CAPTURE (ST_IDLE to ST_LOAD) and T_STREAM (ST_LOAD to ST_LOAD), and both are taken whenever the input strobe is high. Two transitions lead into ST_IDLE: T_DRAIN (ST_LOAD to ST_IDLE) and T_REST (ST_IDLE to ST_IDLE), and both are taken whenever the strobe is low. Reset forces ST_IDLE.

Top module: `adcz_window_compressor`

## Requirements
- R1: With SHORT_W=4, a sample in 248..263 inclusive is short. Its code is sample-248 and sits in out_short bits [4*i+3:4*i] for channel i.
- R2: A sample outside the active window is long. Its full 12-bit value appears in out_long bits [12*i+11:12*i].
- R3: With SHORT_W=5, the window is 248..279 inclusive and the code is sample-248. out_short is then 40 bits wide, with channel i at [5*i+4:5*i].
- R4: out_map bit i is 1 exactly when channel i is long. Channel 7 is the most significant bit.
- R5: A long channel's short field is all zeros, and a short channel's long field is all zeros.
- R6: out_count equals the number of 1 bits in out_map (0 to 8).
- R7: out_valid is high in the cycle after a cycle with in_valid high and low otherwise. The data outputs present the samples captured at that edge.
- R8: When in_valid is low, out_short, out_map, out_long and out_count keep their previous values.
- R9: While rst is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Samples present this cycle |
| in_samples | input | 96 | Eight 12-bit samples, channel i at [12*i+11:12*i] |
| out_valid | output | 1 | Registered result valid |
| out_short | output | 8*SHORT_W | Packed short codes |
| out_map | output | 8 | Long-channel map, 1 = long |
| out_long | output | 96 | Long values, zero for short channels |
| out_count | output | 4 | Number of long channels |

## Verification
The strobe properties assume that in_valid is held low for as long as rst is high. This is because the first clocked check after reset looks back at the strobe one edge earlier. The bench drives the strobe low throughout reset and changes inputs only just after rising edges, so each edge sees settled samples. Stimulus deliberately crosses both window edges in both widths (247/248, 263/264, 279/280), plus the extremes 0 and 4095. It also inserts idle gaps, so that ST_LOAD-to-ST_IDLE drains and held outputs are exercised alongside back-to-back crossings.

// File: rtl/adcz_pkg.sv
package adcz_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } adcz_state_e;

    localparam int ADCZ_PEDESTAL_LO = 248;
endpackage

// File: rtl/adcz_classify.sv
module adcz_classify #(
    parameter int SAMPLE_W = 12,
    parameter int SHORT_W  = 4,
    parameter int PED_LO   = 248
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                is_long,
    output logic [SHORT_W-1:0]  short_code,
    output logic [SAMPLE_W-1:0] long_val
);
    localparam int              HI_INT = PED_LO + (1 << SHORT_W) - 1;
    localparam logic [SAMPLE_W-1:0] LO_V = SAMPLE_W'(PED_LO);
    localparam logic [SAMPLE_W-1:0] HI_V = SAMPLE_W'(HI_INT);

    logic in_win;

    always_comb begin
        in_win     = (sample >= LO_V) && (sample <= HI_V);
        is_long    = !in_win;
        short_code = in_win ? SHORT_W'(sample - LO_V) : '0;
        long_val   = in_win ? '0 : sample;
    end
endmodule

// File: rtl/adcz_popcount.sv
module adcz_popcount #(
    parameter int N     = 8,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     bits,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        count = '0;
        for (int k = 0; k < N; k++) begin
            count = count + CNT_W'(bits[k]);
        end
    end
endmodule

// File: rtl/adcz_window_compressor.sv
module adcz_window_compressor
    import adcz_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int SAMPLE_W = 12,
    parameter int SHORT_W  = 4,
    parameter int PED_LO   = ADCZ_PEDESTAL_LO,
    localparam int CNT_W   = $clog2(NCH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [NCH*SAMPLE_W-1:0] in_samples,
    output logic                    out_valid,
    output logic [NCH*SHORT_W-1:0]  out_short,
    output logic [NCH-1:0]          out_map,
    output logic [NCH*SAMPLE_W-1:0] out_long,
    output logic [CNT_W-1:0]        out_count
);
    adcz_state_e state_q, state_d;

    logic [NCH-1:0]          map_c;
    logic [NCH*SHORT_W-1:0]  short_c;
    logic [NCH*SAMPLE_W-1:0] long_c;
    logic [CNT_W-1:0]        count_c;

    logic [NCH-1:0]          map_q;
    logic [NCH*SHORT_W-1:0]  short_q;
    logic [NCH*SAMPLE_W-1:0] long_q;
    logic [CNT_W-1:0]        count_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        adcz_classify #(
            .SAMPLE_W(SAMPLE_W),
            .SHORT_W (SHORT_W),
            .PED_LO  (PED_LO)
        ) u_cls (
            .sample    (in_samples[g*SAMPLE_W +: SAMPLE_W]),
            .is_long   (map_c[g]),
            .short_code(short_c[g*SHORT_W +: SHORT_W]),
            .long_val  (long_c[g*SAMPLE_W +: SAMPLE_W])
        );

        // p_exclusive_r5: a long slot carries no short code, a short slot no long value
        p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
            out_map[g] ? (out_short[g*SHORT_W +: SHORT_W] == '0)
                       : (out_long[g*SAMPLE_W +: SAMPLE_W] == '0));
    end

    adcz_popcount #(.N(NCH), .CNT_W(CNT_W)) u_cnt (
        .bits (map_c),
        .count(count_c)
    );

    // next-state: T_CAPTURE / T_STREAM on strobe, T_DRAIN / T_REST without
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_LOAD : ST_IDLE;
            ST_LOAD: state_d = in_valid ? ST_LOAD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q   <= '0;
            short_q <= '0;
            long_q  <= '0;
            count_q <= '0;
        end else if (in_valid) begin
            map_q   <= map_c;
            short_q <= short_c;
            long_q  <= long_c;
            count_q <= count_c;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_LOAD);
        out_map   = map_q;
        out_short = short_q;
        out_long  = long_q;
        out_count = count_q;
    end

    p_valid_lag_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_map) && $stable(out_short) &&
                       $stable(out_long) && $stable(out_count)));
    p_count_r6: assert property (@(posedge clk) disable iff (rst)
        out_count == CNT_W'($countones(out_map)));
endmodule

// File: tb/tb_adcz_window_compressor.sv
module tb_adcz_window_compressor;
    localparam int NCH = 8;
    localparam int SW  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [95:0]   in_samples = '0;

    logic          v4, v5;
    logic [31:0]   sh4;
    logic [39:0]   sh5;
    logic [7:0]    mp4, mp5;
    logic [95:0]   lg4, lg5;
    logic [3:0]    ct4, ct5;

    int vectors = 0;
    int errors  = 0;
    bit started = 1'b0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    adcz_window_compressor #(.SHORT_W(4)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(v4), .out_short(sh4), .out_map(mp4), .out_long(lg4), .out_count(ct4));

    adcz_window_compressor #(.SHORT_W(5)) dut5 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(v5), .out_short(sh5), .out_map(mp5), .out_long(lg5), .out_count(ct5));

    // behavioural expectation, one register stage deep
    logic        e_v = 0;
    logic [31:0] e_sh4 = 0;
    logic [39:0] e_sh5 = 0;
    logic [7:0]  e_mp4 = 0, e_mp5 = 0;
    logic [95:0] e_lg4 = 0, e_lg5 = 0;
    int          e_ct4 = 0, e_ct5 = 0;

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            e_v = 0; e_sh4 = 0; e_sh5 = 0; e_mp4 = 0; e_mp5 = 0;
            e_lg4 = 0; e_lg5 = 0; e_ct4 = 0; e_ct5 = 0;
        end else begin
            e_v = in_valid;
            if (in_valid) begin
                e_sh4 = 0; e_sh5 = 0; e_mp4 = 0; e_mp5 = 0;
                e_lg4 = 0; e_lg5 = 0; e_ct4 = 0; e_ct5 = 0;
                for (int c = 0; c < NCH; c++) begin
                    int s;
                    s = int'(in_samples[c*SW +: SW]);
                    if (s >= 248 && s <= 263) e_sh4[c*4 +: 4] = 4'(s - 248);
                    else begin e_mp4[c] = 1; e_lg4[c*SW +: SW] = 12'(s); e_ct4++; end
                    if (s >= 248 && s <= 279) e_sh5[c*5 +: 5] = 5'(s - 248);
                    else begin e_mp5[c] = 1; e_lg5[c*SW +: SW] = 12'(s); e_ct5++; end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            // R9 is covered by these same compares while rst is high; R8 by idle cycles
            if (v4 !== e_v || v5 !== e_v) begin errors++;
                $display("FAIL R7 valid: got %b/%b exp %b", v4, v5, e_v); end
            if (mp4 !== e_mp4 || mp5 !== e_mp5) begin errors++;
                $display("FAIL R4 map: got %h/%h exp %h/%h", mp4, mp5, e_mp4, e_mp5); end
            if (sh4 !== e_sh4) begin errors++;
                $display("FAIL R1 short4: got %h exp %h", sh4, e_sh4); end
            if (sh5 !== e_sh5) begin errors++;
                $display("FAIL R3 short5: got %h exp %h", sh5, e_sh5); end
            if (lg4 !== e_lg4 || lg5 !== e_lg5) begin errors++;
                $display("FAIL R2/R5 long: got %h/%h exp %h/%h", lg4, lg5, e_lg4, e_lg5); end
            if (int'(ct4) != e_ct4 || int'(ct5) != e_ct5) begin errors++;
                $display("FAIL R6 count: got %0d/%0d exp %0d/%0d", ct4, ct5, e_ct4, e_ct5); end
        end
    end

    task automatic drive(input logic [95:0] s, input logic v);
        @(posedge clk); #1;
        in_samples = s;
        in_valid   = v;
    endtask

    function automatic logic [95:0] pack(input int a0, a1, a2, a3, a4, a5, a6, a7);
        logic [95:0] r;
        r = {12'(a7), 12'(a6), 12'(a5), 12'(a4), 12'(a3), 12'(a2), 12'(a1), 12'(a0)};
        return r;
    endfunction

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // R1/R3 window edges in both widths
        drive(pack(247, 248, 263, 264, 279, 280, 0, 4095), 1);
        drive(pack(250, 251, 252, 253, 254, 255, 256, 257), 1);  // all short
        drive(pack(0, 100, 4095, 2048, 300, 1, 512, 247), 1);    // all long, R6 = 8
        drive(pack(248, 0, 0, 0, 0, 0, 0, 263), 1);              // R4 map ordering
        drive(pack(1, 2, 3, 4, 5, 6, 7, 8), 0);                   // R8 ignored
        drive(pack(9, 9, 9, 9, 9, 9, 9, 9), 0);
        drive(pack(270, 265, 279, 280, 248, 263, 264, 262), 1);
        drive('0, 0);
        for (int n = 0; n < 400; n++) begin
            logic [95:0] s;
            for (int c = 0; c < NCH; c++)
                s[c*SW +: SW] = ($urandom % 3 == 0) ? 12'($urandom % 4096)
                                                    : 12'(240 + $urandom % 48);
            drive(s, ($urandom % 5) != 0);
        end
        drive('0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule